// File: doc/BRIEF.md
# Three-Phase Gate Driver Fault Supervisor

This block is the protection logic behind a six-output, three-phase half-bridge gate driver. It takes an overcurrent trip flag, an active-high enable, a low-side supply undervoltage flag, and one undervoltage flag and one high-side command per phase. It decides when the gate outputs may switch. Every input is asynchronous. Each one passes through a two-flop synchroniser before any logic reads it.

The block drives three things. The first is a global `gate_permit`, which is the AND term applied to all six gate outputs. The second is a per-phase `hs_arm`, which lets that phase's high-side output follow its command. The third is an active-low `fault_n`, which stands for an open-drain pin: low means pulled down, high means released. An overcurrent trip only counts once it has stayed high through a blanking window. After the trip goes away, the fault holds for a clear delay measured in clock cycles, where a board would use an RC network. The delay restarts if the trip returns. An undervoltage on the low-side supply pulls the fault low without latching. Enable gates the outputs but never reaches the fault pin. A phase whose high-side supply sagged is re-armed only by a fresh rising command edge.

`BLANK_CYC` (at least 1) sets the blanking window and `CLR_CYC` (at least 2) sets the clear delay, both in clock cycles. "Input set before edge k" below means the input changes between two rising edges, and edge k is the next rising edge.

Top module: `drv_fault_sup`

## Requirements
- R1: While reset is held, and in the cycles that follow until inputs change, `fault_n` is 1, `gate_permit` is 0 and every `hs_arm` bit is 0.
- R2: Every input passes a two-flop synchroniser. An enable rise set before edge k makes `gate_permit` 1 after edge k+1, given no fault.
- R3: A trip input that is high for fewer than `BLANK_CYC` consecutive cycles has no effect on `fault_n` or `gate_permit`.
- R4: A trip held high from before edge k drives both `fault_n` and `gate_permit` to 0 in the same cycle, after edge k+1+`BLANK_CYC`.
- R5: A trip dropped before edge k keeps `fault_n` at 0 until edge k+2+`CLR_CYC`. After that edge `fault_n` returns to 1 without any other action.
- R6: If a qualified trip returns while the clear delay is running, `fault_n` stays 0 and the full clear delay starts again from the new drop.
- R7: Enable low drives `gate_permit` to 0 two edges after the change. Enable is not latched: `gate_permit` returns two edges after enable rises again.
- R8: Enable has no effect on `fault_n`.
- R9: Low-side undervoltage drives `fault_n` and `gate_permit` to 0 two edges after it is set. Both release two edges after it clears, with no latching.
- R10: Undervoltage on phase i clears `hs_arm[i]` after edge k+2 and leaves the other phases unchanged.
- R11: `hs_arm[i]` becomes 1 only on a rising edge of the synchronised command for phase i while that phase's undervoltage is clear, visible after edge k+2 for a command set before edge k. A command that is already high when the undervoltage clears does not re-arm the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | 1 | Overcurrent comparator flag, active high |
| en_in | input | 1 | Output enable, active high |
| ls_uv_in | input | 1 | Low-side supply undervoltage flag |
| hs_uv_in | input | NUM_PH | Per-phase high-side supply undervoltage flags |
| hs_cmd_in | input | NUM_PH | Per-phase high-side gate commands, active high |
| gate_permit | output | 1 | Global permit for all six gate outputs |
| hs_arm | output | NUM_PH | Per-phase high-side arm state |
| fault_n | output | 1 | Fault indication, low while asserted |

## Verification
The assertions read the synchronised copies of the inputs. They assume those copies are clean levels that change only at clock edges. They also assume the clear delay is long enough that a trip burst and its release window overlap in the cases that matter. The stimulus changes inputs only at falling clock edges. Random trip bursts range from shorter than the blanking window to several times its length, so both filtered and qualified trips occur, and some return while a clear delay is running. Enable, undervoltage and command toggles run at separate rates, so every combination of fault sources overlaps.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // bit positions inside the synchroniser bus
  localparam int unsigned IDX_TRIP = 0;
  localparam int unsigned IDX_EN   = 1;
  localparam int unsigned IDX_LSUV = 2;
  localparam int unsigned IDX_HSUV = 3;

  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_HELD  = 2'd1,
    TR_CLEAR = 2'd2
  } trip_st_e;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[b];
        stab <= meta;
      end
    end
    assign q[b] = stab;
  end
endmodule

// File: rtl/fsup_trip_ctrl.sv
module fsup_trip_ctrl
  import fsup_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 40,
  parameter int unsigned CLR_CYC   = 165000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_s,
  output logic trip_act,
  output logic trip_fault
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam int unsigned CW = $clog2(CLR_CYC + 1);
  localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] CLR_FIRST = CW'(1);

  logic [BW-1:0] blank_cnt;
  logic [CW-1:0] clr_cnt;
  trip_st_e      st;

  // qualification: trip must persist through the blanking window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  blank_cnt <= '0;
    else if (!trip_s)            blank_cnt <= '0;
    else if (blank_cnt != BLANK_V) blank_cnt <= blank_cnt + 1'b1;
  end

  assign trip_act = (blank_cnt == BLANK_V);

  // hold and self-clearing delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TR_IDLE;
      clr_cnt <= '0;
    end else begin
      unique case (st)
        TR_IDLE: if (trip_act) st <= TR_HELD;
        TR_HELD: if (!trip_act) begin
          st      <= TR_CLEAR;
          clr_cnt <= CLR_FIRST;   // the HELD cycle after the drop counts as one
        end
        TR_CLEAR: begin
          if (trip_act) begin
            st <= TR_HELD;
          end else if (clr_cnt == CLR_LAST) begin
            st      <= TR_IDLE;
            clr_cnt <= '0;
          end else begin
            clr_cnt <= clr_cnt + 1'b1;
          end
        end
        default: st <= TR_IDLE;
      endcase
    end
  end

  assign trip_fault = trip_act | (st != TR_IDLE);
endmodule

// File: rtl/fsup_hs_arm.sv
module fsup_hs_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_s,
  input  logic uv_s,
  output logic arm
);
  logic cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d <= 1'b0;
      arm   <= 1'b0;
    end else begin
      cmd_d <= cmd_s;
      if (uv_s)                arm <= 1'b0;
      else if (cmd_s && !cmd_d) arm <= 1'b1;
    end
  end
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
  import fsup_pkg::*;
#(
  parameter int unsigned NUM_PH    = 3,
  parameter int unsigned BLANK_CYC = 40,
  parameter int unsigned CLR_CYC   = 165000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_in,
  input  logic              en_in,
  input  logic              ls_uv_in,
  input  logic [NUM_PH-1:0] hs_uv_in,
  input  logic [NUM_PH-1:0] hs_cmd_in,
  output logic              gate_permit,
  output logic [NUM_PH-1:0] hs_arm,
  output logic              fault_n
);
  localparam int unsigned SW      = IDX_HSUV + 2 * NUM_PH;
  localparam int unsigned IDX_CMD = IDX_HSUV + NUM_PH;

  logic [SW-1:0]     raw_bus, syn_bus;
  logic              trip_s, en_s, ls_uv_s;
  logic [NUM_PH-1:0] hs_uv_s, hs_cmd_s;
  logic              trip_act, trip_fault, fault_q;

  assign raw_bus = {hs_cmd_in, hs_uv_in, ls_uv_in, en_in, trip_in};

  fsup_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (syn_bus)
  );

  assign trip_s   = syn_bus[IDX_TRIP];
  assign en_s     = syn_bus[IDX_EN];
  assign ls_uv_s  = syn_bus[IDX_LSUV];
  assign hs_uv_s  = syn_bus[IDX_HSUV +: NUM_PH];
  assign hs_cmd_s = syn_bus[IDX_CMD +: NUM_PH];

  fsup_trip_ctrl #(.BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)) u_trip (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_s     (trip_s),
    .trip_act   (trip_act),
    .trip_fault (trip_fault)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    fsup_hs_arm u_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_s (hs_cmd_s[p]),
      .uv_s  (hs_uv_s[p]),
      .arm   (hs_arm[p])
    );
  end

  // undervoltage on the low side is a live level, never held
  assign fault_q     = trip_fault | ls_uv_s;
  assign fault_n     = ~fault_q;
  assign gate_permit = en_s & ~fault_q;
endmodule

// File: rtl/drv_fault_sup_chk.sv
module drv_fault_sup_chk #(
  parameter int unsigned NUM_PH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trip_act,
  input logic              en_s,
  input logic              ls_uv_s,
  input logic [NUM_PH-1:0] hs_uv_s,
  input logic [NUM_PH-1:0] hs_cmd_s,
  input logic              gate_permit,
  input logic [NUM_PH-1:0] hs_arm,
  input logic              fault_n
);
  p_trip_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_act |-> (!gate_permit && !fault_n));

  p_hold_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_act) |-> !fault_n);

  p_release_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (!trip_act && !ls_uv_s && !$past(trip_act)));

  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> !gate_permit);

  p_lsuv_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_uv_s |-> (!fault_n && !gate_permit));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    p_hsuv_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hs_uv_s[p] |=> !hs_arm[p]);

    p_rearm_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_arm[p]) |-> ($past(hs_cmd_s[p]) && !$past(hs_uv_s[p])));
  end
endmodule

bind drv_fault_sup drv_fault_sup_chk #(.NUM_PH(NUM_PH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trip_act    (trip_act),
  .en_s        (en_s),
  .ls_uv_s     (ls_uv_s),
  .hs_uv_s     (hs_uv_s),
  .hs_cmd_s    (hs_cmd_s),
  .gate_permit (gate_permit),
  .hs_arm      (hs_arm),
  .fault_n     (fault_n)
);

// File: tb/tb_drv_fault_sup.sv
module tb_drv_fault_sup;
  localparam int NP = 3;
  localparam int BL = 5;
  localparam int CL = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_in = 0, en_in = 0, ls_uv_in = 0;
  logic [NP-1:0] hs_uv_in = '0, hs_cmd_in = '0;
  logic gate_permit, fault_n;
  logic [NP-1:0] hs_arm;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  drv_fault_sup #(.NUM_PH(NP), .BLANK_CYC(BL), .CLR_CYC(CL)) dut (
    .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .en_in(en_in),
    .ls_uv_in(ls_uv_in), .hs_uv_in(hs_uv_in), .hs_cmd_in(hs_cmd_in),
    .gate_permit(gate_permit), .hs_arm(hs_arm), .fault_n(fault_n));

  // ---------------- reference model built from the requirements -------------
  logic [8:0] m1, m2;
  int mcnt, mst, mclr;
  logic [NP-1:0] mcd, marm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = '0; m2 = '0; mcnt = 0; mst = 0; mclr = 0; mcd = '0; marm = '0;
    end else begin
      automatic bit act = (mcnt == BL);
      for (int i = 0; i < NP; i++) begin
        if (m2[3+i]) marm[i] = 1'b0;
        else if (m2[6+i] && !mcd[i]) marm[i] = 1'b1;
      end
      mcd = m2[8:6];
      case (mst)
        0: if (act) mst = 1;
        1: if (!act) begin mst = 2; mclr = 1; end
        default: if (act) mst = 1;
                 else if (mclr == CL - 1) begin mst = 0; mclr = 0; end
                 else mclr++;
      endcase
      if (!m2[0]) mcnt = 0; else if (mcnt != BL) mcnt++;
      m2 = m1;
      m1 = {hs_cmd_in, hs_uv_in, ls_uv_in, en_in, trip_in};
    end
  end

  function automatic bit exp_fault_n();
    return !(((mcnt == BL) || (mst != 0)) || m2[2]);
  endfunction
  function automatic bit exp_permit();
    return m2[1] && exp_fault_n();
  endfunction

  task automatic expect_int(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: wait for falling edge, compare every output with the model
  task automatic step(string req);
    @(negedge clk);
    expect_int({req, " fault_n"}, int'(fault_n), int'(exp_fault_n()));
    expect_int({req, " gate_permit"}, int'(gate_permit), int'(exp_permit()));
    expect_int({req, " hs_arm"}, int'(hs_arm), int'(marm));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit seen_hi;
    int trip_left;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset values
    expect_int("R1 fault_n in reset", int'(fault_n), 1);
    expect_int("R1 hs_arm in reset", int'(hs_arm), 0);
    rst_n = 1'b1;
    repeat (4) step("R1");
    expect_int("R1 permit after reset", int'(gate_permit), 0);
    expect_int("R1 arm after reset", int'(hs_arm), 0);

    // R2: two-flop latency on enable
    en_in = 1;
    n = 0; do begin step("R2"); n++; end while (gate_permit !== 1'b1 && n < 50);
    expect_int("R2 enable latency", n, 2);

    // R3: trip shorter than blanking is ignored
    trip_in = 1;
    repeat (BL - 1) step("R3");
    trip_in = 0;
    seen_hi = 1;
    repeat (12) begin step("R3"); if (fault_n !== 1'b1 || gate_permit !== 1'b1) seen_hi = 0; end
    expect_int("R3 short trip ignored", int'(seen_hi), 1);

    // R4: qualified trip latency, outputs together
    trip_in = 1;
    n = 0; do begin step("R4"); n++; end while (fault_n !== 1'b0 && n < 50);
    expect_int("R4 trip latency", n, BL + 2);
    expect_int("R4 permit with fault", int'(gate_permit), 0);

    // R5: clear delay then self release
    repeat (8) step("R5");
    trip_in = 0;
    n = 0; do begin step("R5"); n++; end while (fault_n !== 1'b1 && n < CL + 50);
    expect_int("R5 clear delay", n, CL + 3);

    // R6: retrip inside clear window restarts it
    trip_in = 1;
    repeat (BL + 6) step("R6");
    trip_in = 0;
    repeat (CL / 2) step("R6");
    trip_in = 1;
    seen_hi = 0;
    repeat (BL + 4) begin step("R6"); if (fault_n === 1'b1) seen_hi = 1; end
    trip_in = 0;
    n = 0; do begin step("R6"); n++; if (fault_n === 1'b1 && n < CL + 3) seen_hi = 1; end
      while (fault_n !== 1'b1 && n < CL + 50);
    expect_int("R6 fault held through retrip", int'(seen_hi), 0);
    expect_int("R6 restarted delay", n, CL + 3);

    // R7 and R8: enable gates permit, not latched, never touches fault_n
    en_in = 0;
    n = 0; do begin step("R7"); n++; end while (gate_permit !== 1'b0 && n < 50);
    expect_int("R7 disable latency", n, 2);
    expect_int("R8 fault_n with enable low", int'(fault_n), 1);
    en_in = 1;
    n = 0; do begin step("R7"); n++; end while (gate_permit !== 1'b1 && n < 50);
    expect_int("R7 not latched", n, 2);
    seen_hi = 1;
    for (int k = 0; k < 10; k++) begin
      en_in = k[0];
      step("R8");
      if (fault_n !== 1'b1) seen_hi = 0;
    end
    expect_int("R8 enable toggles leave fault_n", int'(seen_hi), 1);
    en_in = 1;
    repeat (3) step("R8");

    // R9: low-side undervoltage, unlatched
    ls_uv_in = 1;
    n = 0; do begin step("R9"); n++; end while (fault_n !== 1'b0 && n < 50);
    expect_int("R9 uv assert latency", n, 2);
    expect_int("R9 permit off", int'(gate_permit), 0);
    ls_uv_in = 0;
    n = 0; do begin step("R9"); n++; end while (fault_n !== 1'b1 && n < 50);
    expect_int("R9 uv release latency", n, 2);
    expect_int("R9 permit back", int'(gate_permit), 1);

    // R10 and R11: per-phase high-side re-arm
    hs_cmd_in = '1;
    n = 0; do begin step("R11"); n++; end while (hs_arm !== 3'b111 && n < 50);
    expect_int("R11 arm on rising command", n, 3);
    hs_uv_in = 3'b010;
    n = 0; do begin step("R10"); n++; end while (hs_arm[1] !== 1'b0 && n < 50);
    expect_int("R10 uv clear latency", n, 3);
    expect_int("R10 other phases kept", int'(hs_arm), 3'b101);
    hs_uv_in = '0;
    repeat (10) step("R11");
    expect_int("R11 level does not re-arm", int'(hs_arm), 3'b101);
    hs_cmd_in[1] = 0;
    repeat (4) step("R11");
    hs_cmd_in[1] = 1;
    n = 0; do begin step("R11"); n++; end while (hs_arm[1] !== 1'b1 && n < 50);
    expect_int("R11 fresh edge re-arms", n, 3);

    // constrained random mix, every cycle compared to the model
    trip_left = 0;
    for (int c = 0; c < 4000; c++) begin
      step("R5 random");
      if (trip_left > 0) begin
        trip_left--;
        if (trip_left == 0) trip_in = 0;
      end else if ($urandom_range(39) == 0) begin
        trip_in = 1;
        trip_left = $urandom_range(3 * BL, 1);
      end
      if ($urandom_range(59) == 0) ls_uv_in = ~ls_uv_in;
      if ($urandom_range(19) == 0) en_in = ~en_in;
      for (int i = 0; i < NP; i++) begin
        if ($urandom_range(49) == 0) hs_uv_in[i] = ~hs_uv_in[i];
        if ($urandom_range(3) == 0) hs_cmd_in[i] = ~hs_cmd_in[i];
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule